// File: doc/BRIEF.md
# Constant Divider by Reciprocal Multiplication

This block divides a 32-bit unsigned dividend by one of a small set of fixed divisors. It returns the quotient and the remainder, and it never runs an iterative division loop. A 3-bit select chooses the divisor for each beat. The select is decoded into three things: a precomputed reciprocal coefficient, a post-shift and the divisor itself.

The quotient is the upper word of the full 64-bit product of the dividend and the coefficient, shifted right by the post-shift. The power-of-two divisor skips the multiply and shifts the dividend directly. The remainder is derived from the quotient: it is the dividend minus the divisor times the quotient.

The unit is a fixed three-stage pipeline with one input strobe and one output strobe. It accepts a new operand every cycle, and each beat may use a different select.

Top module: `cdiv_const_divider`

## Requirements
- R1: Select codes map to divisors as follows: 0 is 3, 1 is 5, 2 is 10, 3 is 100, 4 is 125, 5 is 1000. For each of these codes and for every 32-bit dividend x, the quotient equals floor(x / divisor).
- R2: For every valid select, the remainder equals x minus divisor times the quotient, which lies in [0, divisor).
- R3: Select code 7 is unassigned. It returns quotient 0, remainder 0 and the error flag set to 1. Every assigned code returns the error flag as 0.
- R4: The output strobe rises exactly 3 clock cycles after the input strobe that carried the operand. The quotient, the remainder and the error flag presented with it belong to that operand.
- R5: Operands presented on consecutive cycles, each with its own select, all come out in order on consecutive cycles with correct results.
- R6: While reset is held, and directly after it, the output strobe, quotient, remainder and error flag are all 0.
- R7: Select code 6 divides by 8. The quotient is x shifted right by 3, and the remainder is x[2:0].
- R8: In a cycle where the output strobe is 0, the quotient, remainder and error flag keep the values of the last result that was delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| in_sel | input | 3 | Divisor select code |
| in_dividend | input | 32 | Unsigned dividend |
| out_valid | output | 1 | Result strobe, 3 cycles after in_valid |
| out_quot | output | 32 | Quotient |
| out_rem | output | 32 | Remainder |
| out_err | output | 1 | Set when the select code is unassigned |

## Verification
The bench applies dividends of 0, 1, c-1, c, c+1 and 2^32-1 on every code.

- A coefficient one unit too small shows up as a quotient one low at exact multiples of the divisor.
- A coefficient that rounds too coarsely overshoots by one near 2^32-1.
- A wrong post-shift halves or doubles every quotient.

The bench also mixes random selects with random bubbles. A pipeline that pairs a select with the wrong dividend stage fails on those mixes. So does one that updates its outputs during bubbles, or one that lets the unassigned code leak a nonzero result.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int DW    = 32;
  localparam int PW    = 2 * DW;
  localparam int SEL_W = 3;
  localparam int SHW   = 3;

  typedef struct packed {
    logic [DW-1:0]  magic;
    logic [DW-1:0]  divisor;
    logic [SHW-1:0] shift;
    logic           bypass;   // power of two: no multiply
    logic           known;    // select code is assigned
  } coef_t;

  function automatic coef_t coef_of(input logic [SEL_W-1:0] code);
    coef_t c;
    c = '0;
    c.known = 1'b1;
    case (code)
      3'd0: begin c.magic = 32'hAAAA_AAAB; c.divisor = 32'd3;    c.shift = 3'd1; end
      3'd1: begin c.magic = 32'hCCCC_CCCD; c.divisor = 32'd5;    c.shift = 3'd2; end
      3'd2: begin c.magic = 32'hCCCC_CCCD; c.divisor = 32'd10;   c.shift = 3'd3; end
      3'd3: begin c.magic = 32'h51EB_851F; c.divisor = 32'd100;  c.shift = 3'd5; end
      3'd4: begin c.magic = 32'h1062_4DD3; c.divisor = 32'd125;  c.shift = 3'd3; end
      3'd5: begin c.magic = 32'h1062_4DD3; c.divisor = 32'd1000; c.shift = 3'd6; end
      3'd6: begin c.divisor = 32'd8; c.shift = 3'd3; c.bypass = 1'b1; end
      default: c.known = 1'b0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/cdiv_coef_lookup.sv
module cdiv_coef_lookup
  import cdiv_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output coef_t            coef
);
  always_comb coef = coef_of(sel);
endmodule

// File: rtl/cdiv_product_stage.sv
module cdiv_product_stage
  import cdiv_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           a_valid,
  input  logic [DW-1:0]  a_x,
  input  coef_t          a_coef,
  output logic           p_valid,
  output logic [DW-1:0]  p_x,
  output logic [DW-1:0]  p_hi,
  output logic [DW-1:0]  p_divisor,
  output logic [SHW-1:0] p_shift,
  output logic           p_bypass,
  output logic           p_known
);
  logic [PW-1:0] prod;

  always_comb prod = {{DW{1'b0}}, a_x} * {{DW{1'b0}}, a_coef.magic};

  always_ff @(posedge clk) begin
    if (rst) begin
      p_valid   <= 1'b0;
      p_x       <= '0;
      p_hi      <= '0;
      p_divisor <= '0;
      p_shift   <= '0;
      p_bypass  <= 1'b0;
      p_known   <= 1'b0;
    end else begin
      p_valid   <= a_valid;
      p_x       <= a_x;
      p_hi      <= prod[PW-1:DW];
      p_divisor <= a_coef.divisor;
      p_shift   <= a_coef.shift;
      p_bypass  <= a_coef.bypass;
      p_known   <= a_coef.known;
    end
  end

  // The high word never exceeds the dividend, since every coefficient is below 2^32
  AST_HI_BOUND: assert property (@(posedge clk) disable iff (rst)
    p_valid && !p_bypass |-> p_hi <= p_x); // R1
endmodule

// File: rtl/cdiv_finish_stage.sv
module cdiv_finish_stage
  import cdiv_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           p_valid,
  input  logic [DW-1:0]  p_x,
  input  logic [DW-1:0]  p_hi,
  input  logic [DW-1:0]  p_divisor,
  input  logic [SHW-1:0] p_shift,
  input  logic           p_bypass,
  input  logic           p_known,
  output logic           o_valid,
  output logic [DW-1:0]  o_quot,
  output logic [DW-1:0]  o_rem,
  output logic           o_err
);
  logic [DW-1:0] q_src, q_nxt, r_nxt, o_div;

  generate
    if (DW > 0) begin : g_quot
      always_comb begin
        q_src = p_bypass ? p_x : p_hi;
        q_nxt = p_known ? (q_src >> p_shift) : '0;
        r_nxt = p_known ? (p_x - p_divisor * q_nxt) : '0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_quot  <= '0;
      o_rem   <= '0;
      o_err   <= 1'b0;
      o_div   <= '0;
    end else begin
      o_valid <= p_valid;
      if (p_valid) begin
        o_quot <= q_nxt;
        o_rem  <= r_nxt;
        o_err  <= ~p_known;
        o_div  <= p_divisor;
      end
    end
  end

  AST_REM_BELOW_DIV: assert property (@(posedge clk) disable iff (rst)
    o_valid && !o_err |-> o_rem < o_div); // R2
  AST_RECOMBINE: assert property (@(posedge clk) disable iff (rst)
    o_valid && !o_err |->
      (64'(o_quot) * 64'(o_div) + 64'(o_rem)) == 64'($past(p_x))); // R2
  AST_BAD_SEL_ZERO: assert property (@(posedge clk) disable iff (rst)
    o_valid && o_err |-> (o_quot == '0) && (o_rem == '0)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !o_valid && !$past(rst) |-> $stable(o_quot) && $stable(o_rem) && $stable(o_err)); // R8
endmodule

// File: rtl/cdiv_const_divider.sv
module cdiv_const_divider
  import cdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [SEL_W-1:0] in_sel,
  input  logic [DW-1:0]    in_dividend,
  output logic             out_valid,
  output logic [DW-1:0]    out_quot,
  output logic [DW-1:0]    out_rem,
  output logic             out_err
);
  logic             a_valid;
  logic [SEL_W-1:0] a_sel;
  logic [DW-1:0]    a_x;
  coef_t            a_coef;

  logic             p_valid, p_bypass, p_known;
  logic [DW-1:0]    p_x, p_hi, p_divisor;
  logic [SHW-1:0]   p_shift;

  logic [1:0]       warm_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid <= 1'b0;
      a_sel   <= '0;
      a_x     <= '0;
    end else begin
      a_valid <= in_valid;
      a_sel   <= in_sel;
      a_x     <= in_dividend;
    end
  end

  cdiv_coef_lookup u_lookup (.sel(a_sel), .coef(a_coef));

  cdiv_product_stage u_prod (
    .clk(clk), .rst(rst), .a_valid(a_valid), .a_x(a_x), .a_coef(a_coef),
    .p_valid(p_valid), .p_x(p_x), .p_hi(p_hi), .p_divisor(p_divisor),
    .p_shift(p_shift), .p_bypass(p_bypass), .p_known(p_known)
  );

  cdiv_finish_stage u_fin (
    .clk(clk), .rst(rst), .p_valid(p_valid), .p_x(p_x), .p_hi(p_hi),
    .p_divisor(p_divisor), .p_shift(p_shift), .p_bypass(p_bypass),
    .p_known(p_known), .o_valid(out_valid), .o_quot(out_quot),
    .o_rem(out_rem), .o_err(out_err)
  );

  always_ff @(posedge clk) begin
    if (rst) warm_cnt <= '0;
    else if (warm_cnt != 2'd3) warm_cnt <= warm_cnt + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    warm_cnt == 2'd3 |-> out_valid == $past(in_valid, 3)); // R4
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> !out_valid && !out_err && out_quot == '0 && out_rem == '0); // R6
endmodule

// File: tb/cdiv_const_divider_test.sv
module cdiv_const_divider_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_sel = '0;
  logic [31:0] in_dividend = '0;
  logic        out_valid, out_err;
  logic [31:0] out_quot, out_rem;

  int checks = 0;
  int errors = 0;

  logic        hv[3];
  logic [2:0]  hs[3];
  logic [31:0] hx[3];
  logic [31:0] last_q, last_r;
  logic        last_e;

  always #4 clk = ~clk;

  cdiv_const_divider uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sel(in_sel),
    .in_dividend(in_dividend), .out_valid(out_valid), .out_quot(out_quot),
    .out_rem(out_rem), .out_err(out_err)
  );

  function automatic logic [31:0] div_of(input logic [2:0] s);
    case (s)
      3'd0: return 32'd3;
      3'd1: return 32'd5;
      3'd2: return 32'd10;
      3'd3: return 32'd100;
      3'd4: return 32'd125;
      3'd5: return 32'd1000;
      3'd6: return 32'd8;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge: check the result due now, then drive the next operand
  task automatic beat(input logic v, input logic [2:0] s, input logic [31:0] x);
    logic [31:0] c, eq, er;
    @(negedge clk);
    chk(out_valid == hv[2], "R4 strobe", 32'(out_valid), 32'(hv[2]));
    if (hv[2]) begin
      c  = div_of(hs[2]);
      eq = (c == 0) ? 32'd0 : hx[2] / c;
      er = (c == 0) ? 32'd0 : hx[2] % c;
      if (c == 0) begin
        chk(out_err == 1'b1, "R3 err", 32'(out_err), 32'd1);
        chk(out_quot == 0 && out_rem == 0, "R3 zero", out_quot | out_rem, 32'd0);
      end else begin
        chk(out_err == 1'b0, "R3 err", 32'(out_err), 32'd0);
        chk(out_quot == eq, (hs[2] == 3'd6) ? "R7 quot" : "R1 quot", out_quot, eq);
        chk(out_rem == er, (hs[2] == 3'd6) ? "R7 rem" : "R2 rem", out_rem, er);
      end
      last_q = out_quot; last_r = out_rem; last_e = out_err;
    end else begin
      chk(out_quot == last_q && out_rem == last_r && out_err == last_e,
          "R8 hold", out_quot, last_q);
    end
    hv[2] = hv[1]; hs[2] = hs[1]; hx[2] = hx[1];
    hv[1] = hv[0]; hs[1] = hs[0]; hx[1] = hx[0];
    hv[0] = v;     hs[0] = s;     hx[0] = x;
    in_valid = v; in_sel = s; in_dividend = x;
  endtask

  initial begin
    int unsigned seed;
    logic [31:0] c;
    for (int i = 0; i < 3; i++) begin hv[i] = 0; hs[i] = 0; hx[i] = 0; end
    last_q = 0; last_r = 0; last_e = 0;
    seed = $urandom(32'd20251);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && !out_err && out_quot == 0 && out_rem == 0, "R6 reset",
        out_quot | out_rem | 32'(out_valid), 32'd0);
    rst = 1'b0;
    // Directed corners, back to back (R5)
    for (int s = 0; s < 8; s++) begin
      c = div_of(3'(s));
      beat(1, 3'(s), 32'd0);
      beat(1, 3'(s), 32'd1);
      beat(1, 3'(s), c - 32'd1);
      beat(1, 3'(s), c);
      beat(1, 3'(s), c + 32'd1);
      beat(1, 3'(s), 32'hFFFF_FFFF);
      beat(1, 3'(s), 32'hFFFF_FFFF - c);
    end
    repeat (3) beat(0, 3'd0, 32'd0);
    // Random mix with bubbles and near-multiple dividends (R1 R2 R5 R8)
    for (int n = 0; n < 20000; n++) begin
      logic [2:0]  s;
      logic [31:0] x;
      s = 3'($urandom_range(0, 7));
      x = $urandom;
      if ($urandom_range(0, 3) == 0 && div_of(s) != 0)
        x = (x / div_of(s)) * div_of(s) - 32'($urandom_range(0, 1));
      beat($urandom_range(0, 4) != 0, s, x);
    end
    repeat (4) beat(0, 3'd0, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule